// File: doc/BRIEF.md
# Tagged Receive/Transmit FIFO Data Port

This block is the register-side data port of a serial frame controller. It has two FIFOs. The transmit FIFO holds bytes: a bus write places a byte in it, and the transmit serial logic takes bytes out in order. The receive FIFO holds entries that each carry a data byte and three side-band tags: end-of-frame, CRC error and overrun. The receive serial logic fills it. A bus read removes the oldest receive entry but returns only its data byte. On the same clock edge, the entry's three tags are copied into a read-only status register, which software reads to learn how the byte ended.

Each FIFO has its own enable. While an enable is low, its FIFO is flushed and held empty. When the receive side pushes into a full receive FIFO, the incoming value is dropped, and the overrun tag is set on the newest entry still stored. That tag therefore reaches the status register when software reads the last byte that survived. Each FIFO has a three-state occupancy machine:

- States: EMPTY, PARTIAL and FULL.
- Transitions:
  - *fill* (EMPTY→PARTIAL on an accepted push),
  - *top-off* (PARTIAL→FULL when a push alone brings the count to the depth),
  - *drain* (PARTIAL→EMPTY when a pop alone takes the count to zero),
  - *release* (FULL→PARTIAL when a pop alone is accepted),
  - *flush* (any state→EMPTY while the enable is low).

The machine drives the full and empty flags.

Top module: `tagged_fifo_port`

## Requirements
- R1: After reset both FIFOs are empty with count 0, and `bus_rdata` and all three status bits are 0.
- R2: A bus write with `tx_en` high appends `bus_wdata` to the transmit FIFO. `tx_byte` always shows the oldest byte. Each `tx_pop` removes one byte, so bytes leave in write order.
- R3: A bus write to a full transmit FIFO (8 entries by default) is ignored. The count stays 8 and the stored bytes are unchanged.
- R4: A receive entry is 11 bits wide:
  - bits 7..0 are data,
  - bit 8 is end-of-frame,
  - bit 9 is CRC error,
  - bit 10 is overrun.

  A bus read of a non-empty receive FIFO returns only bits 7..0 on `bus_rdata`, registered on the edge where `bus_rd` is sampled.
- R5: On that same edge, bits 8, 9 and 10 of the popped entry are copied into `stat_eof`, `stat_crc_err` and `stat_overrun`.
- R6: The status bits hold their value on every cycle without a bus read.
- R7: A bus read of an empty receive FIFO sets `bus_rdata` to 0 and leaves the status bits unchanged.
- R8: A receive push into a full receive FIFO (12 entries by default) that is not paired with a pop is dropped. The count stays full, and the overrun tag (bit 10) of the most recently stored entry becomes 1.
- R9: While `tx_en` is 0, the transmit FIFO is flushed to empty on the next edge, and bus writes are not stored.
- R10: While `rx_en` is 0, the receive FIFO is flushed to empty on the next edge, and receive pushes are not stored.
- R11: Each FIFO's count equals its occupancy. Empty is asserted exactly when the count is 0, and full exactly when the count equals the depth.
- R12: A push and a pop on the same edge into a full FIFO are both accepted. The count stays at the depth, and order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; low flushes the transmit FIFO |
| rx_en | input | 1 | Receive enable; low flushes the receive FIFO |
| bus_wr | input | 1 | Bus write strobe to the data register |
| bus_wdata | input | 8 | Byte written to the transmit FIFO |
| bus_rd | input | 1 | Bus read strobe of the data register |
| bus_rdata | output | 8 | Data byte of the last read entry, 0 on an empty read |
| stat_eof | output | 1 | End-of-frame tag of the last read entry |
| stat_crc_err | output | 1 | CRC-error tag of the last read entry |
| stat_overrun | output | 1 | Overrun tag of the last read entry |
| tx_pop | input | 1 | Transmit serial logic takes one byte |
| tx_byte | output | 8 | Oldest byte in the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_count | output | 4 | Transmit FIFO occupancy |
| rx_push | input | 1 | Receive serial logic offers one entry |
| rx_byte | input | 8 | Data byte of the offered entry |
| rx_eof_in | input | 1 | End-of-frame tag of the offered entry |
| rx_crc_in | input | 1 | CRC-error tag of the offered entry |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_count | output | 4 | Receive FIFO occupancy |

## Verification
The assertions check several rules on every cycle:
- flags and count agree with each other;
- a flush empties the FIFO on the next edge;
- a refused push leaves a full FIFO full;
- a paired push and pop keeps it full;
- the status bits stay put between reads;
- an empty read yields zero.

Other behaviour shows only through the bench's scenarios, because it depends on data carried across many cycles:
- that the right tags land on the right byte;
- that the overrun mark sits on the twelfth stored entry rather than on another;
- that refused bytes never reappear;
- that order survives simultaneous push and pop.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

    typedef enum logic [1:0] {
        FIFO_EMPTY   = 2'd0,
        FIFO_PARTIAL = 2'd1,
        FIFO_FULL    = 2'd2
    } fifo_state_e;

    localparam int TAG_COUNT   = 3;
    localparam int TAG_EOF_OFS = 0;
    localparam int TAG_CRC_OFS = 1;
    localparam int TAG_ROR_OFS = 2;

endpackage

// File: rtl/fifo_core.sv
module fifo_core
    import fifo_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic [WIDTH-1:0] tail_mark,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);

    fifo_state_e state, state_n;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr, tail_idx;
    logic             pop_ok, push_ok, refused;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok   = pop && (state != FIFO_EMPTY) && !flush;
    assign push_ok  = push && !flush && ((state != FIFO_FULL) || pop_ok);
    assign refused  = push && !flush && (state == FIFO_FULL) && !pop_ok;
    assign tail_idx = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
    assign head_data = mem[rd_ptr];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FIFO_EMPTY;
        else        state <= state_n;
    end

    // next state: fill, top-off, drain, release, flush
    always_comb begin
        state_n = state;
        if (flush) begin
            state_n = FIFO_EMPTY;
        end else begin
            unique case (state)
                FIFO_EMPTY:
                    if (push_ok) state_n = FIFO_PARTIAL;
                FIFO_PARTIAL:
                    if (push_ok && !pop_ok && count == CW'(DEPTH - 1))
                        state_n = FIFO_FULL;
                    else if (pop_ok && !push_ok && count == CW'(1))
                        state_n = FIFO_EMPTY;
                FIFO_FULL:
                    if (pop_ok && !push_ok) state_n = FIFO_PARTIAL;
                default:
                    state_n = FIFO_EMPTY;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        full  = (state == FIFO_FULL);
        empty = (state == FIFO_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end else if (refused) begin
            mem[tail_idx] <= mem[tail_idx] | tail_mark;
        end
    end

    // R11: flags agree with the count held in a separate register
    assert_flags_match_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == CW'(DEPTH))));

    // R9 and R10: flush empties the FIFO on the next edge
    assert_flush_empties_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && count == '0));

    // R3 and R8: a refused push leaves a full FIFO full
    assert_no_overflow_R3_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && count == CW'(DEPTH)));

    // R12: paired push and pop keeps a full FIFO full
    assert_swap_keeps_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop && !flush) |=> full);

endmodule

// File: rtl/tagged_fifo_port.sv
module tagged_fifo_port
    import fifo_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 12,
    localparam int RX_W  = DATA_W + TAG_COUNT,
    localparam int TXC_W = $clog2(TX_DEPTH + 1),
    localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stat_eof,
    output logic              stat_crc_err,
    output logic              stat_overrun,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [TXC_W-1:0]  tx_count,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_eof_in,
    input  logic              rx_crc_in,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [RXC_W-1:0]  rx_count
);

    localparam logic [RX_W-1:0] ROR_MARK = RX_W'(1) << (DATA_W + TAG_ROR_OFS);

    logic [RX_W-1:0]      rx_entry, rx_head;
    logic [TAG_COUNT-1:0] head_tags;

    fifo_core #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!tx_en),
        .push      (bus_wr),
        .push_data (bus_wdata),
        .pop       (tx_pop),
        .tail_mark ('0),
        .head_data (tx_byte),
        .full      (tx_full),
        .empty     (tx_empty),
        .count     (tx_count)
    );

    always_comb begin
        rx_entry = '0;
        rx_entry[DATA_W-1:0]              = rx_byte;
        rx_entry[DATA_W + TAG_EOF_OFS]    = rx_eof_in;
        rx_entry[DATA_W + TAG_CRC_OFS]    = rx_crc_in;
    end

    fifo_core #(.WIDTH(RX_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_en),
        .push      (rx_push),
        .push_data (rx_entry),
        .pop       (bus_rd),
        .tail_mark (ROR_MARK),
        .head_data (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .count     (rx_count)
    );

    assign head_tags = rx_head[RX_W-1:DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata    <= '0;
            stat_eof     <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_overrun <= 1'b0;
        end else if (bus_rd) begin
            if (!rx_empty && rx_en) begin
                bus_rdata    <= rx_head[DATA_W-1:0];
                stat_eof     <= head_tags[TAG_EOF_OFS];
                stat_crc_err <= head_tags[TAG_CRC_OFS];
                stat_overrun <= head_tags[TAG_ROR_OFS];
            end else begin
                bus_rdata <= '0;
            end
        end
    end

    // R7: empty read gives zero and keeps status
    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rx_empty) |=> (bus_rdata == '0 &&
            $stable(stat_eof) && $stable(stat_crc_err) && $stable(stat_overrun)));

    // R6: status holds between reads
    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> ($stable(stat_eof) && $stable(stat_crc_err) && $stable(stat_overrun)));

    // R5: status updates only when an entry leaves the receive FIFO
    assert_status_moves_on_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({stat_eof, stat_crc_err, stat_overrun}) |-> $past(bus_rd && !rx_empty));

endmodule

// File: tb/tagged_fifo_port_tb.sv
module tagged_fifo_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {crc, eof, data}
    localparam logic [9:0] RX_VEC [NVEC] = '{
        10'h0_5A, 10'h1_33, 10'h2_C4, 10'h3_FF, 10'h0_00, 10'h1_81
    };

    logic clk = 0, rst_n = 0;
    logic tx_en = 0, rx_en = 0, bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0;
    logic [7:0] bus_wdata = 0, rx_byte = 0;
    logic rx_eof_in = 0, rx_crc_in = 0;
    logic [7:0] bus_rdata, tx_byte;
    logic stat_eof, stat_crc_err, stat_overrun, tx_full, tx_empty, rx_full, rx_empty;
    logic [3:0] tx_count, rx_count;
    int checks = 0, failures = 0;
    logic [7:0] b;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_fifo_port u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .stat_eof(stat_eof), .stat_crc_err(stat_crc_err), .stat_overrun(stat_overrun),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_count(tx_count), .rx_push(rx_push), .rx_byte(rx_byte), .rx_eof_in(rx_eof_in),
        .rx_crc_in(rx_crc_in), .rx_full(rx_full), .rx_empty(rx_empty), .rx_count(rx_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1; bus_wdata = d; @(negedge clk); bus_wr = 0;
    endtask
    task automatic push(input logic [7:0] d, input logic e, input logic c);
        rx_push = 1; rx_byte = d; rx_eof_in = e; rx_crc_in = c; @(negedge clk);
        rx_push = 0; rx_eof_in = 0; rx_crc_in = 0;
    endtask
    task automatic rd();
        bus_rd = 1; @(negedge clk); bus_rd = 0;
    endtask
    task automatic pop(output logic [7:0] d);
        d = tx_byte; tx_pop = 1; @(negedge clk); tx_pop = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
        chk("R1 counts", {tx_count, rx_count}, 0); chk("R1 rdata", bus_rdata, 0);
        chk("R1 status", {stat_overrun, stat_crc_err, stat_eof}, 0);
        tx_en = 1; rx_en = 1; @(negedge clk);

        // table walk: R4 R5
        for (int i = 0; i < NVEC; i++) push(RX_VEC[i][7:0], RX_VEC[i][8], RX_VEC[i][9]);
        chk("R11 rx_count table", rx_count, NVEC);
        for (int i = 0; i < NVEC; i++) begin
            rd();
            chk("R4 rdata byte only", bus_rdata, RX_VEC[i][7:0]);
            chk("R5 status tags", {stat_overrun, stat_crc_err, stat_eof}, {1'b0, RX_VEC[i][9:8]});
        end
        // R6 hold, then R7 empty read
        repeat (3) @(negedge clk);
        chk("R6 status hold", {stat_overrun, stat_crc_err, stat_eof}, 3'b001);
        rd();
        chk("R7 empty read zero", bus_rdata, 0);
        chk("R7 status unchanged", {stat_overrun, stat_crc_err, stat_eof}, 3'b001);

        // R2 R3 R11 transmit fill
        for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i));
        chk("R11 tx_full", {tx_full, tx_count}, {1'b1, 4'd8});
        wr(8'hEE);
        chk("R3 count after refused write", tx_count, 8);
        for (int i = 0; i < 8; i++) begin
            pop(b);
            chk("R2 R3 tx order", b, 8'h10 + 8'(i));
        end
        chk("R11 tx_empty after drain", {tx_empty, tx_count}, {1'b1, 4'd0});

        // R12 simultaneous push and pop when full
        for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i));
        b = tx_byte; bus_wr = 1; bus_wdata = 8'h99; tx_pop = 1; @(negedge clk);
        bus_wr = 0; tx_pop = 0;
        chk("R12 popped head", b, 8'h20);
        chk("R12 stays full", {tx_full, tx_count}, {1'b1, 4'd8});
        for (int i = 1; i < 8; i++) begin
            pop(b);
            chk("R12 order kept", b, 8'h20 + 8'(i));
        end
        pop(b);
        chk("R12 new byte last", b, 8'h99);

        // R8 receive overrun marks 12th entry
        for (int i = 0; i < 12; i++) push(8'h40 + 8'(i), 0, 0);
        chk("R11 rx_full", {rx_full, rx_count}, {1'b1, 4'd12});
        push(8'hAA, 0, 0); push(8'hBB, 1, 1);
        chk("R8 count stays 12", rx_count, 12);
        for (int i = 0; i < 11; i++) begin
            rd();
            chk("R8 earlier entries clean", {stat_overrun, bus_rdata}, {1'b0, 8'h40 + 8'(i)});
        end
        rd();
        chk("R8 last stored byte", bus_rdata, 8'h4B);
        chk("R8 overrun tag", {stat_overrun, stat_crc_err, stat_eof}, 3'b100);
        chk("R8 dropped values gone", rx_empty, 1);

        // R9 transmit enable low
        wr(8'h01); wr(8'h02);
        tx_en = 0; @(negedge clk);
        chk("R9 tx flushed", {tx_empty, tx_count}, {1'b1, 4'd0});
        wr(8'h03);
        chk("R9 write while disabled", tx_count, 0);
        tx_en = 1; @(negedge clk);

        // R10 receive enable low
        push(8'h07, 1, 0); push(8'h08, 0, 0);
        rx_en = 0; @(negedge clk);
        chk("R10 rx flushed", {rx_empty, rx_count}, {1'b1, 4'd0});
        push(8'h09, 0, 0);
        chk("R10 push while disabled", rx_count, 0);
        rx_en = 1; @(negedge clk);
        rd();
        chk("R10 read after flush zero", bus_rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule